// File: doc/BRIEF.md
# Decimator Timing and Sync Controller

This block paces a decimation filter that runs from a 1.024 MHz input clock. A 3-bit bandwidth code sets the output word period, and a counter divides the input clock by that period. At the end of each period the block raises a data-ready strobe. The filter arithmetic is outside this block. The block drives it through two signals: a one-cycle clear pulse, and a level that tells the filter it may run.

The block samples three control inputs on rising clock edges:

- A reset request stops the filter and parks the timing. It leaves the filter contents alone.
- A power-down request stops the modulator clock and freezes the period counter. The counter keeps its position while frozen.
- A sync request restarts the period counter and clears the filter. Data-ready then rises exactly one output period after the sync edge.

A sync that lands on the phase the counter already holds is absorbed without a clear. Because of this, a single sync pulse, a sync held high and a sync repeated at the word rate all give the same output timing. Data-ready changes only on falling clock edges.

Top module: `dec_seq_ctrl`

## Requirements
- R1: Let N be `BASE_DIV` (4096 by default). The output period is N >> c input clocks for bandwidth code c = 0..6. Code 7 gives the same period as code 6. With a 1.024 MHz clock and the default N, codes 0..6 give periods of 4 ms, 2 ms, 1 ms, 1/2 ms, 1/4 ms, 1/8 ms and 1/16 ms.
- R2: A sync event happens on a rising edge E when `sync_req_i` is 1, it was 0 at the previous edge, and neither reset nor power-down is requested. An event that restarts the phase drives `flt_clear_o` high for the one cycle after E. `data_rdy_o` then rises on the falling edge that follows edge E+P, where P is the period.
- R3: If `sync_req_i` stays high, only one event happens. `flt_clear_o` is never high for two cycles in a row.
- R4: A sync event on the edge that ends a period (counter at P-1 while running) is absorbed. It produces no clear and does not shift the timing, so sync pulses at the word rate leave the output exactly as a single pulse would.
- R5: `data_rdy_o` changes only on falling clock edges.
- R6: `data_rdy_o` goes low when `rd_ack_i` is sampled high, unless a period ends on that same edge. With no acknowledge, it goes low one clock before the next period boundary, so with period P it is high P-1 cycles out of every P.
- R7: While `rst_req_i` is sampled high, `conv_run_o` is 0, `data_rdy_o` is 0, `mclk_en_o` is 1 even if power-down is also requested, the counter is held at zero, and no clear is issued. On the first edge F with `rst_req_i` low, `conv_run_o` goes to 1, and data-ready rises one period after F without any filter clear.
- R8: On the first edge where `pwr_down_i` is sampled high (and no reset is requested), `mclk_en_o` and `conv_run_o` go to 0 and the counter freezes. Sync requests are ignored while powered down. On the first edge with `pwr_down_i` low, both outputs return to 1. The counter stays frozen on that edge and counts on from the next edge.
- R9: While `rst_ni` is low, the outputs are `mclk_en_o`=1, `conv_run_o`=0, `flt_clear_o`=0 and `data_rdy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock (1.024 MHz nominal) |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| rst_req_i | input | 1 | Reset request, sampled on rising edges |
| pwr_down_i | input | 1 | Power-down request, sampled on rising edges |
| sync_req_i | input | 1 | Sync request; its rising level starts a new phase |
| bw_sel_i | input | 3 | Bandwidth code selecting the output period |
| rd_ack_i | input | 1 | Read acknowledge; drops data-ready |
| flt_clear_o | output | 1 | One-cycle filter clear pulse |
| conv_run_o | output | 1 | Filter convolution enable |
| mclk_en_o | output | 1 | Modulator clock enable |
| data_rdy_o | output | 1 | Data-ready strobe, updated on falling edges |

## Verification
The hardest case to reach is a sync that arrives exactly on the edge where the counter wraps. Only there does the absorb path of R4 decide the outcome, and it must produce no clear and no phase shift. The bench starts every phase from a known point: it releases a reset request with sync raised on the same edge. From that edge it counts edges in the bench and raises sync one cycle before each multiple of the period. A second hard case is a sync edge that falls inside a power-down window. The bench places the freeze at a known counter value and predicts the delayed data-ready edge arithmetically from the number of frozen edges.

// File: rtl/dec_seq_pkg.sv
package dec_seq_pkg;

  localparam logic [2:0] BW_RSVD = 3'd7;
  localparam logic [2:0] BW_FAST = 3'd6;

  // reserved code aliases the fastest rate
  function automatic logic [2:0] bw_shift(input logic [2:0] code);
    return (code == BW_RSVD) ? BW_FAST : code;
  endfunction

endpackage

// File: rtl/dec_edge_det.sv
module dec_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);

  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= d_i;
  end

  assign rise_o = d_i & ~d_q;

  assert_rise_once_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/dec_rate_ctr.sv
module dec_rate_ctr #(
  parameter int unsigned CW = 12,
  localparam int unsigned PW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          restart_i,
  input  logic          adv_i,
  input  logic [PW-1:0] period_i,
  output logic          last_o,
  output logic          late_o,
  output logic          tick_o
);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] cnt_ext;

  assign cnt_ext = {1'b0, cnt_q};
  // >= keeps the wrap safe when the code shrinks mid-period
  assign last_o  = cnt_ext >= (period_i - PW'(1));
  assign late_o  = cnt_ext == (period_i - PW'(2));
  assign tick_o  = adv_i & last_o & ~hold_i & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (hold_i | restart_i) cnt_q <= '0;
    else if (adv_i)              cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  assert_hold_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));

  assert_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !hold_i && !restart_i) |=> $stable(cnt_q));

endmodule

// File: rtl/dec_drdy_gen.sv
module dec_drdy_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic rdy_o
);

  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdy_q <= 1'b0;
    else if (hold_i) rdy_q <= 1'b0;
    else if (set_i)  rdy_q <= 1'b1;
    else if (clr_i)  rdy_q <= 1'b0;
  end

  // output retimed to the falling edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_o <= 1'b0;
    else         rdy_o <= rdy_q;
  end

  assert_hold_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !rdy_q);

  assert_clr_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !rdy_q);

  assert_set_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !hold_i) |=> rdy_q);

endmodule

// File: rtl/dec_seq_ctrl.sv
module dec_seq_ctrl #(
  parameter int unsigned BASE_DIV = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_req_i,
  input  logic       pwr_down_i,
  input  logic       sync_req_i,
  input  logic [2:0] bw_sel_i,
  input  logic       rd_ack_i,
  output logic       flt_clear_o,
  output logic       conv_run_o,
  output logic       mclk_en_o,
  output logic       data_rdy_o
);

  import dec_seq_pkg::*;

  localparam int unsigned CW = $clog2(BASE_DIV);
  localparam int unsigned PW = CW + 1;
  localparam logic [PW-1:0] BASE_PER = PW'(BASE_DIV);

  logic          sync_rise, fire, aligned, restart, adv;
  logic          last, late, tick;
  logic          run_q, pd_q, clr_q;
  logic [PW-1:0] period;

  assign period = BASE_PER >> bw_shift(bw_sel_i);

  dec_edge_det u_sync_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_req_i),
    .rise_o (sync_rise)
  );

  assign adv     = run_q & ~rst_req_i & ~pwr_down_i;
  assign fire    = sync_rise & ~rst_req_i & ~pwr_down_i;
  // sync landing on the natural wrap is absorbed
  assign aligned = fire & run_q & last;
  assign restart = fire & ~aligned;

  dec_rate_ctr #(.CW(CW)) u_rate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (rst_req_i),
    .restart_i (restart),
    .adv_i     (adv),
    .period_i  (period),
    .last_o    (last),
    .late_o    (late),
    .tick_o    (tick)
  );

  dec_drdy_gen u_drdy (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (rst_req_i),
    .set_i  (tick),
    .clr_i  (restart | late | rd_ack_i),
    .rdy_o  (data_rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      pd_q  <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      run_q <= ~rst_req_i & ~pwr_down_i;
      pd_q  <= ~rst_req_i & pwr_down_i;
      clr_q <= restart;
    end
  end

  assign flt_clear_o = clr_q;
  assign conv_run_o  = run_q;
  assign mclk_en_o   = ~pd_q;

  assert_clear_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_clear_o |=> !flt_clear_o);

  assert_reset_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (!conv_run_o && mclk_en_o && !flt_clear_o));

  assert_pd_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_down_i && !rst_req_i) |=> (!mclk_en_o && !conv_run_o));

  assert_pd_no_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |=> !flt_clear_o);

endmodule

// File: tb/dec_seq_ctrl_test.sv
module dec_seq_ctrl_test;

  localparam int unsigned BASE = 128;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rst_req = 1'b0, pwr_down = 1'b0, sync_req = 1'b0, rd_ack = 1'b0;
  logic [2:0] bw_sel = 3'd0;
  logic       flt_clear, conv_run, mclk_en, data_rdy;

  int tests = 0;
  int fails = 0;
  bit r5_on = 1'b0;
  logic last_rdy = 1'b0;

  always #4 clk = ~clk;

  dec_seq_ctrl #(.BASE_DIV(BASE)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .rst_req_i   (rst_req),
    .pwr_down_i  (pwr_down),
    .sync_req_i  (sync_req),
    .bw_sel_i    (bw_sel),
    .rd_ack_i    (rd_ack),
    .flt_clear_o (flt_clear),
    .conv_run_o  (conv_run),
    .mclk_en_o   (mclk_en),
    .data_rdy_o  (data_rdy)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one rising edge; data_rdy must not move at the rising edge (R5)
  task automatic step();
    @(posedge clk);
    #1;
    if (r5_on) check("R5 rdy stable at rising edge", data_rdy, last_rdy);
    #6;
    last_rdy = data_rdy;
  endtask

  function automatic int per_of(input int c);
    return BASE >> ((c == 7) ? 6 : c);
  endfunction

  // expected data_rdy j edges after phase start, with period p
  function automatic int exp_rdy(input int j, input int p);
    return (j >= p && (j % p) != p - 1) ? 1 : 0;
  endfunction

  // reset request for two edges, release with sync raised: observation left at edge E
  task automatic start_phase(input int code, input bit keep_sync);
    bw_sel = 3'(code);
    rst_req = 1'b1;
    step();
    step();
    check("R7 conv_run in reset", conv_run, 0);
    check("R7 rdy in reset", data_rdy, 0);
    check("R7 mclk_en in reset", mclk_en, 1);
    check("R7 no clear in reset", flt_clear, 0);
    rst_req = 1'b0;
    sync_req = 1'b1;
    step();
    if (!keep_sync) sync_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step();
    step();
    check("R9 mclk_en at power-up", mclk_en, 1);
    check("R9 conv_run at power-up", conv_run, 0);
    check("R9 clear at power-up", flt_clear, 0);
    check("R9 rdy at power-up", data_rdy, 0);
    rst_ni = 1'b1;
    step();
    r5_on = 1'b1;

    // R1 R2: every bandwidth code, single sync pulse
    for (int c = 0; c < 8; c++) begin
      int p;
      p = per_of(c);
      start_phase(c, 1'b0);
      for (int j = 0; j < 2 * p + 2; j++) begin
        if (j > 0) step();
        check($sformatf("R1 R2 rdy code %0d j %0d", c, j), data_rdy, exp_rdy(j, p));
        check("R2 clear pulse", flt_clear, (j == 0) ? 1 : 0);
        check("R2 conv_run", conv_run, 1);
      end
    end

    // R3: sync held high
    begin
      int p;
      p = per_of(3);
      start_phase(3, 1'b1);
      for (int j = 0; j < 3 * p; j++) begin
        if (j > 0) step();
        check("R3 rdy with held sync", data_rdy, exp_rdy(j, p));
        check("R3 single clear", flt_clear, (j == 0) ? 1 : 0);
      end
      sync_req = 1'b0;
    end

    // R4: sync repeated at the word rate
    begin
      int p;
      p = per_of(4);
      start_phase(4, 1'b0);
      for (int j = 0; j < 4 * p; j++) begin
        if (j > 0) step();
        check("R4 rdy with word-rate sync", data_rdy, exp_rdy(j, p));
        check("R4 aligned sync no clear", flt_clear, (j == 0) ? 1 : 0);
        sync_req = ((j + 1) % p == 0) ? 1'b1 : 1'b0;
      end
      sync_req = 1'b0;
    end

    // R6: acknowledge drops data-ready early
    begin
      int p;
      p = per_of(2);
      start_phase(2, 1'b0);
      for (int j = 0; j <= 2 * p; j++) begin
        if (j > 0) step();
        if (j <= p + 3) check("R6 rdy before ack", data_rdy, exp_rdy(j, p));
        else if (j < 2 * p) check("R6 rdy low after ack", data_rdy, 0);
        else check("R6 rdy next period", data_rdy, 1);
        rd_ack = (j == p + 3) ? 1'b1 : 1'b0;
      end
      rd_ack = 1'b0;
    end

    // R7: reset request mid-run, also against power-down
    begin
      int p;
      p = per_of(2);
      start_phase(2, 1'b0);
      for (int j = 1; j <= p; j++) step();
      check("R7 rdy high before reset", data_rdy, 1);
      rst_req = 1'b1;
      step();
      check("R7 rdy forced low", data_rdy, 0);
      check("R7 conv_run low", conv_run, 0);
      check("R7 mclk_en default", mclk_en, 1);
      pwr_down = 1'b1;
      step();
      check("R7 reset beats power-down", mclk_en, 1);
      check("R7 no clear on reset", flt_clear, 0);
      pwr_down = 1'b0;
      rst_req = 1'b0;
      step();
      for (int j = 0; j <= 2 * p + 1; j++) begin
        if (j > 0) step();
        check("R7 rdy after release", data_rdy, exp_rdy(j, p));
        check("R7 no clear after release", flt_clear, 0);
        check("R7 conv_run after release", conv_run, 1);
      end
    end

    // R8: power-down freezes timing; sync ignored inside the window
    begin
      int p;
      p = per_of(3);
      start_phase(3, 1'b0);
      for (int j = 0; j <= p + 7; j++) begin
        if (j > 0) step();
        if (j >= 3 && j <= 7) begin
          check("R8 mclk_en low", mclk_en, 0);
          check("R8 conv_run low", conv_run, 0);
        end else begin
          check("R8 mclk_en high", mclk_en, 1);
          check("R8 conv_run high", conv_run, 1);
        end
        if (j > 0) check("R8 no clear", flt_clear, 0);
        check("R8 delayed rdy", data_rdy, (j == p + 6 || j == p + 7) ? 1 : 0);
        pwr_down = (j >= 2 && j <= 6) ? 1'b1 : 1'b0;
        sync_req = (j == 4) ? 1'b1 : 1'b0;
      end
      pwr_down = 1'b0;
      sync_req = 1'b0;
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule